// File: doc/BRIEF.md
# Interrupt Source Event State Buffer

This block holds the event state of one interrupt source as two bits: P ("an event has been sent and is not yet acknowledged") and Q ("another event arrived while P was set"). Software reaches the block through a small load/store register window. The operation is chosen by the access offset and by the access direction, and the data of a store carries no meaning. A hardware trigger input lets the source itself raise events. When an event finds the source idle, the block sends a one-cycle notify pulse to the interrupt router and sets P. Further events while P is set are folded into the single Q bit, so the router sees at most one outstanding notification.

Every load returns the state as it was before the load's own effect. A handler can therefore acknowledge, mask, unmask or inspect the source and learn the prior state in the same access. A typical unmask is a load that writes PQ = 00. If that load returns Q = 1, an event was lost while masked, and software issues a store trigger to replay it. The source leaves reset masked (PQ = 01).

Top module: `pq_event_buffer`

## Requirements
- R1: After reset the state is PQ = 01 (masked). notify and rsp_valid are low until an access or trigger is accepted.
- R2: A load returns data with P in bit 1, Q in bit 0 and all other bits zero. The data is the state from before that load's effect. rsp_valid is high for exactly the cycle after each load, and a store never produces a response.
- R3: A trigger that finds PQ = 00 moves the state to 10 and raises notify for one cycle.
- R4: A trigger that finds P = 1 leaves P at 1 and sets Q (10 goes to 11, 11 stays 11), with no notify.
- R5: A trigger that finds PQ = 01 has no effect on the state and gives no notify.
- R6: An EOI is a load at offset 0x000 or a store at offset 0x400. It moves 10 to 00, and it moves 11 to 10 with a one-cycle notify. It leaves 00 and 01 unchanged with no notify.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 respectively (offset bits 9:8 give the new P,Q). They never raise notify.
- R8: A store at offset 0x000 is a software trigger, with the same effect as the hardware trigger input.
- R9: When a register access and hw_trigger arrive in the same cycle, the access is applied first and the trigger is then applied to the result. notify is raised if either step asks for it.
- R10: A store at any offset other than 0x000 and 0x400 changes nothing. A load at any offset other than 0x000 and 0xC00-0xF00 only returns the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_offset | input | OFS_W | Byte offset of the access inside the window |
| hw_trigger | input | 1 | Event from the source hardware |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data: bit 1 = P, bit 0 = Q, other bits zero |
| notify | output | 1 | One-cycle event notification to the router |

## Verification
Every result of this block is registered once. The state, the notify pulse and the load response for an access or trigger taken at a rising edge all appear just after that same edge and hold until the next edge. The bench drives each stimulus at a falling edge, lets one rising edge capture it, and compares rsp_valid, rsp_data and notify at the following falling edge. That falling edge is also where the next stimulus is driven. The state is never read directly. The bench infers it from the next query load, which is itself due one edge later.

// File: rtl/pq_esb_pkg.sv
package pq_esb_pkg;

    // Width of the decoded part of the access window
    localparam int unsigned MAP_W = 12;

    localparam logic [MAP_W-1:0] OFS_TRIG_OR_LDEOI = 12'h000;
    localparam logic [MAP_W-1:0] OFS_STORE_EOI     = 12'h400;
    localparam logic [MAP_W-1:0] OFS_SETPQ_BASE    = 12'hC00;
    // Bits 9:8 pick the P,Q value in the set-state group
    localparam logic [MAP_W-1:0] OFS_SETPQ_SEL     = 12'h300;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    localparam pq_t PQ_RESET = '{p: 1'b0, q: 1'b1};

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_TRIGGER,
        OP_EOI,
        OP_SET,
        OP_QUERY,
        OP_DROP
    } op_e;

    typedef struct packed {
        op_e  op;
        pq_t  set_val;
        logic is_load;
    } cmd_t;

    typedef struct packed {
        pq_t  pq;
        logic fire;
    } step_t;

    function automatic step_t trigger_step(pq_t s);
        step_t r;
        r.pq   = s;
        r.fire = 1'b0;
        if (!s.p && !s.q) begin
            r.pq   = '{p: 1'b1, q: 1'b0};
            r.fire = 1'b1;
        end else if (s.p) begin
            r.pq = '{p: 1'b1, q: 1'b1};
        end
        return r;
    endfunction

    function automatic step_t eoi_step(pq_t s);
        step_t r;
        r.pq   = s;
        r.fire = 1'b0;
        if (s.p) begin
            if (s.q) begin
                r.pq   = '{p: 1'b1, q: 1'b0};
                r.fire = 1'b1;
            end else begin
                r.pq = '{p: 1'b0, q: 1'b0};
            end
        end
        return r;
    endfunction

    function automatic step_t cmd_step(pq_t s, cmd_t c);
        step_t r;
        r.pq   = s;
        r.fire = 1'b0;
        case (c.op)
            OP_TRIGGER: r = trigger_step(s);
            OP_EOI:     r = eoi_step(s);
            OP_SET:     r.pq = c.set_val;
            default:    r.pq = s;
        endcase
        return r;
    endfunction

    function automatic cmd_t decode_access(logic valid, logic write, logic in_page,
                                           logic [MAP_W-1:0] ofs);
        cmd_t c;
        c.op      = OP_IDLE;
        c.set_val = '{p: 1'b0, q: 1'b0};
        c.is_load = valid && !write;
        if (valid) begin
            if (!in_page) begin
                c.op = write ? OP_DROP : OP_QUERY;
            end else if (write) begin
                if (ofs == OFS_TRIG_OR_LDEOI)
                    c.op = OP_TRIGGER;
                else if (ofs == OFS_STORE_EOI)
                    c.op = OP_EOI;
                else
                    c.op = OP_DROP;
            end else begin
                if (ofs == OFS_TRIG_OR_LDEOI) begin
                    c.op = OP_EOI;
                end else if ((ofs & ~OFS_SETPQ_SEL) == OFS_SETPQ_BASE) begin
                    c.op      = OP_SET;
                    c.set_val = '{p: ofs[9], q: ofs[8]};
                end else begin
                    c.op = OP_QUERY;
                end
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/pq_cmd_decode.sv
module pq_cmd_decode
    import pq_esb_pkg::*;
#(
    parameter int unsigned OFS_W = 12
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_offset,
    output cmd_t             cmd
);

    logic in_page;

    generate
        if (OFS_W > MAP_W) begin : g_wide
            assign in_page = (req_offset[OFS_W-1:MAP_W] == '0);
        end else begin : g_exact
            assign in_page = 1'b1;
        end
    endgenerate

    logic [MAP_W-1:0] low_ofs;
    assign low_ofs = req_offset[MAP_W-1:0];

    always_comb begin
        cmd = decode_access(req_valid, req_write, in_page, low_ofs);
    end

endmodule

// File: rtl/pq_state_core.sv
module pq_state_core
    import pq_esb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic hw_trigger,
    output pq_t  pq_q,
    output logic notify_q
);

    step_t after_cmd;
    step_t after_trig;

    always_comb begin
        after_cmd = cmd_step(pq_q, cmd);
        if (hw_trigger) begin
            after_trig = trigger_step(after_cmd.pq);
        end else begin
            after_trig.pq   = after_cmd.pq;
            after_trig.fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq_q     <= PQ_RESET;
            notify_q <= 1'b0;
        end else begin
            pq_q     <= after_trig.pq;
            notify_q <= after_cmd.fire | after_trig.fire;
        end
    end

endmodule

// File: rtl/pq_load_resp.sv
module pq_load_resp
    import pq_esb_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_load,
    input  pq_t               pq_before,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int unsigned PAD_W = DATA_W - 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_load;
            if (is_load)
                rsp_data <= {{PAD_W{1'b0}}, pq_before.p, pq_before.q};
        end
    end

endmodule

// File: rtl/pq_event_buffer.sv
module pq_event_buffer
    import pq_esb_pkg::*;
#(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              hw_trigger,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              notify
);

    cmd_t       cmd;
    pq_t        state_pq;
    logic [1:0] cur_pq;

    pq_cmd_decode #(.OFS_W(OFS_W)) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .cmd        (cmd)
    );

    pq_state_core u_core (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .hw_trigger (hw_trigger),
        .pq_q       (state_pq),
        .notify_q   (notify)
    );

    pq_load_resp #(.DATA_W(DATA_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .is_load    (cmd.is_load),
        .pq_before  (state_pq),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    assign cur_pq = {state_pq.p, state_pq.q};

endmodule

// File: rtl/pq_event_buffer_chk.sv
module pq_event_buffer_chk #(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [OFS_W-1:0]  req_offset,
    input logic              hw_trigger,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              notify,
    input logic [1:0]        pq
);

    logic ld;
    logic st;
    logic setpq_ld;
    logic st_eoi;
    assign ld       = req_valid && !req_write;
    assign st       = req_valid && req_write;
    assign setpq_ld = ld && ((req_offset & ~OFS_W'(12'h300)) == OFS_W'(12'hC00));
    assign st_eoi   = st && (req_offset == OFS_W'(12'h400));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pq == 2'b01 && !notify && !rsp_valid));

    a_r2_rsp_on_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> rsp_valid);

    a_r2_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
        !ld |=> !rsp_valid);

    a_r2_old_state: assert property (@(posedge clk) disable iff (rst)
        ld |=> (rsp_data == DATA_W'($past(pq))));

    a_r3_first_event: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && hw_trigger && pq == 2'b00) |=> (pq == 2'b10 && notify));

    a_r4_coalesce: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && hw_trigger && pq[1]) |=> (pq == 2'b11 && !notify));

    a_r5_masked: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && hw_trigger && pq == 2'b01) |=> (pq == 2'b01 && !notify));

    a_r6_replay: assert property (@(posedge clk) disable iff (rst)
        (st_eoi && !hw_trigger && pq == 2'b11) |=> (pq == 2'b10 && notify));

    a_r7_set_state: assert property (@(posedge clk) disable iff (rst)
        (setpq_ld && !hw_trigger) |=> (pq == $past(req_offset[9:8]) && !notify));

endmodule

bind pq_event_buffer pq_event_buffer_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_offset (req_offset),
    .hw_trigger (hw_trigger),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .notify     (notify),
    .pq         (cur_pq)
);

// File: tb/test_pq_event_buffer.sv
`timescale 1ns/1ps
module test_pq_event_buffer;

    localparam int unsigned OFS_W  = 12;
    localparam int unsigned DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [OFS_W-1:0]  req_offset = '0;
    logic              hw_trigger = 1'b0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              notify;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pq_event_buffer #(.OFS_W(OFS_W), .DATA_W(DATA_W)) i_pq_event_buffer (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .hw_trigger (hw_trigger),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .notify     (notify)
    );

    // ld, st, hw, offset, expected rsp_valid, expected P/Q, expected notify, requirement
    typedef struct packed {
        logic        ld;
        logic        st;
        logic        hw;
        logic [11:0] ofs;
        logic        ev;
        logic [1:0]  ed;
        logic        en;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b01, 1'b0, 4'd1 },  // R1 masked out of reset
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd5 },  // R5
        '{1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 4'd5 },  // R5
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b01, 1'b0, 4'd5 },  // R5
        '{1'b1, 1'b0, 1'b0, 12'hC00, 1'b1, 2'b01, 1'b0, 4'd7 },  // R7
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b1, 4'd3 },  // R3
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd4 },  // R4
        '{1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 4'd4 },  // R4
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b11, 1'b0, 4'd4 },  // R4
        '{1'b0, 1'b1, 1'b0, 12'h400, 1'b0, 2'b00, 1'b1, 4'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 12'h000, 1'b1, 2'b10, 1'b0, 4'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b00, 1'b0, 4'd6 },  // R6
        '{1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 2'b00, 1'b1, 4'd8 },  // R8
        '{1'b1, 1'b0, 1'b0, 12'hF00, 1'b1, 2'b10, 1'b0, 4'd7 },  // R7
        '{1'b1, 1'b0, 1'b0, 12'hD00, 1'b1, 2'b11, 1'b0, 4'd7 },  // R7
        '{1'b1, 1'b0, 1'b0, 12'hE00, 1'b1, 2'b01, 1'b0, 4'd7 },  // R7
        '{1'b1, 1'b0, 1'b0, 12'hC00, 1'b1, 2'b10, 1'b0, 4'd7 },  // R7
        '{1'b0, 1'b1, 1'b0, 12'hC00, 1'b0, 2'b00, 1'b0, 4'd10},  // R10
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b00, 1'b0, 4'd10},  // R10
        '{1'b0, 1'b1, 1'b0, 12'h400, 1'b0, 2'b00, 1'b0, 4'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b00, 1'b0, 4'd6 },  // R6
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b1, 4'd3 },  // R3
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd4 },  // R4
        '{1'b1, 1'b0, 1'b0, 12'hC00, 1'b1, 2'b11, 1'b0, 4'd7 },  // R7 Q seen on unmask
        '{1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 2'b00, 1'b1, 4'd8 },  // R8 replay
        '{1'b1, 1'b0, 1'b0, 12'hD00, 1'b1, 2'b10, 1'b0, 4'd7 },  // R7
        '{1'b1, 1'b0, 1'b0, 12'h000, 1'b1, 2'b01, 1'b0, 4'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b01, 1'b0, 4'd6 },  // R6
        '{1'b1, 1'b0, 1'b0, 12'hE00, 1'b1, 2'b01, 1'b0, 4'd7 },  // R7
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 2'b00, 1'b0, 4'd4 },  // R4
        '{1'b0, 1'b1, 1'b1, 12'h400, 1'b0, 2'b00, 1'b1, 4'd9 },  // R9
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b11, 1'b0, 4'd9 },  // R9
        '{1'b1, 1'b0, 1'b1, 12'h000, 1'b1, 2'b11, 1'b1, 4'd9 },  // R9
        '{1'b1, 1'b0, 1'b0, 12'hC00, 1'b1, 2'b11, 1'b0, 4'd9 },  // R9
        '{1'b0, 1'b1, 1'b1, 12'h400, 1'b0, 2'b00, 1'b1, 4'd9 },  // R9
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b10, 1'b0, 4'd9 },  // R9
        '{1'b1, 1'b0, 1'b1, 12'h400, 1'b1, 2'b10, 1'b0, 4'd10},  // R10
        '{1'b1, 1'b0, 1'b0, 12'h800, 1'b1, 2'b11, 1'b0, 4'd10}   // R10
    };

    task automatic check(input string what, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge, outputs due there
    task automatic step(input logic ld, input logic st, input logic hw,
                        input logic [11:0] ofs);
        req_valid  = ld | st;
        req_write  = st;
        req_offset = ofs;
        hw_trigger = hw;
        @(negedge clk);
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_offset = '0;
        hw_trigger = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet after reset
        check("R1 rsp_valid after reset", DATA_W'(rsp_valid), '0);
        check("R1 notify after reset", DATA_W'(notify), '0);
        @(negedge clk);
        check("R1 notify idle", DATA_W'(notify), '0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ld, VECS[i].st, VECS[i].hw, VECS[i].ofs);
            check($sformatf("R%0d vec%0d rsp_valid", VECS[i].rq, i),
                  DATA_W'(rsp_valid), DATA_W'(VECS[i].ev));
            if (VECS[i].ev)
                check($sformatf("R2 R%0d vec%0d rsp_data", VECS[i].rq, i),
                      rsp_data, DATA_W'(VECS[i].ed));
            check($sformatf("R%0d vec%0d notify", VECS[i].rq, i),
                  DATA_W'(notify), DATA_W'(VECS[i].en));
        end

        // R3: notify lasts one cycle only
        step(1'b1, 1'b0, 1'b0, 12'hC00);   // state 00
        step(1'b0, 1'b0, 1'b1, 12'h000);
        check("R3 notify pulse", DATA_W'(notify), 64'd1);
        @(negedge clk);
        check("R3 notify one cycle", DATA_W'(notify), '0);
        check("R2 no response when idle", DATA_W'(rsp_valid), '0);

        // R1: reset from a pending state returns to masked
        step(1'b0, 1'b0, 1'b1, 12'h000);   // 10 -> 11
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 notify in reset", DATA_W'(notify), '0);
        step(1'b1, 1'b0, 1'b0, 12'h800);
        check("R1 state after mid reset", rsp_data, 64'd1);

        // R10: load outside the decoded window only reports state
        step(1'b0, 1'b0, 1'b0, 12'h000);
        step(1'b1, 1'b0, 1'b0, 12'h0C0);
        check("R10 unknown load data", rsp_data, 64'd1);
        step(1'b1, 1'b0, 1'b0, 12'h800);
        check("R10 state kept", rsp_data, 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule